// File: doc/BRIEF.md
# Cache-to-DRAM Block Transfer Controller

This block sits between user logic and a large external memory. User logic sees a 4 KB on-chip cache through one single-port word interface: 1024 words of 32 bits, with read data appearing one clock after the address. To move data in bulk, user logic pulses a load or store command, naming a 15-bit page of external memory and one of the sixteen 256-byte blocks of the cache. A load copies that block from external memory into the cache. A store copies the block from the cache out to external memory.

The external side is a burst port two words wide. The controller issues 32 consecutive beats at the address {page, block, beat}. Before a burst starts, the controller waits while the memory signals that a refresh is in progress. A busy flag covers the whole transfer, and any command that arrives while busy is high is dropped. The user cache port stays usable during a transfer. The user must not write into the block being moved while the transfer runs.

Top module: `blk_xfer_ctrl`

## Requirements
- R1: After reset, busy, ext_rd and ext_wr are all low.
- R2: A word written through the user port at a 10-bit address is returned on usr_rdata one clock after that address is presented with usr_wr low.
- R3: A command accepted while idle raises busy on the next clock. With ext_stall low, busy stays high for exactly 36 clocks.
- R4: A store drives ext_wr for 32 consecutive cycles, starting in the second busy cycle. ext_addr is {page[14:0], block[3:0], beat[4:0]}, with beat counting 0 to 31. ext_wdata[31:0] carries cache word block*64+2*beat, and ext_wdata[63:32] carries word block*64+2*beat+1.
- R5: A load drives ext_rd for 32 consecutive cycles with the same addressing as R4. Each ext_rvalid beat is written into the next word pair of the selected block, low half to the even word. The data can be read through the user port once busy has fallen.
- R6: cmd_load and cmd_store are ignored while busy is high. Such a command neither lengthens the running transfer nor starts another one after it.
- R7: If cmd_load and cmd_store are both high in one idle cycle, a load is performed and no store.
- R8: While ext_stall is high in the first busy cycle and in the cycles that follow it, the burst is held back. Each stalled cycle adds one cycle to busy, and neither ext_rd nor ext_wr is driven during the stall.
- R9: A load writes no cache word outside the selected block.
- R10: User reads of other cache words return correct data while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_addr | input | 10 | User cache word address |
| usr_wr | input | 1 | User write strobe |
| usr_wdata | input | 32 | User write data |
| usr_rdata | output | 32 | User read data, one clock after address |
| cmd_page | input | 15 | External page for the transfer |
| cmd_blk | input | 4 | Cache block index for the transfer |
| cmd_load | input | 1 | Copy block from external memory into cache |
| cmd_store | input | 1 | Copy block from cache to external memory |
| busy | output | 1 | Transfer in progress |
| ext_stall | input | 1 | External memory refresh in progress |
| ext_rd | output | 1 | External read beat request |
| ext_wr | output | 1 | External write beat |
| ext_addr | output | 24 | External beat address {page, block, beat} |
| ext_wdata | output | 64 | External write data, two words |
| ext_rvalid | input | 1 | External read data valid |
| ext_rdata | input | 64 | External read data, two words |

## Verification
Most wrong sequencer states become visible as a busy window of the wrong length, or as a burst that does not run for exactly 32 cycles. A miscounted beat index makes ext_addr skip a step in the very next cycle. A wrong prefetch or lane choice shows up as swapped or shifted words in ext_wdata on the first beat. A wrong receive counter or block latch for a load stays hidden until the cache is read back after busy falls. For that reason the bench reads back the whole block, plus the words just outside it.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_BURST = 2'd2,
      ST_TAIL  = 2'd3
   } xfer_state_t;

   localparam int LANES = 2;
endpackage

// File: rtl/xfer_cache_bank.sv
module xfer_cache_bank #(
   parameter int DW = 32,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic [AW-1:0] a_addr,
   input  logic          a_we,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic [AW-1:0] b_addr,
   input  logic          b_we,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata
);
   localparam int DEPTH = 2 ** AW;

   logic [DW-1:0] mem [DEPTH];

   // user port first; transfer port wins on a same-address collision
   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      if (b_we) mem[b_addr] <= b_wdata;
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
   import blk_xfer_pkg::*;
#(
   parameter int PAGE_W = 15,
   parameter int BLK_W  = 4,
   parameter int BEAT_W = 5,
   parameter int RD_LAT = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_load,
   input  logic                      cmd_store,
   input  logic [PAGE_W-1:0]         cmd_page,
   input  logic [BLK_W-1:0]          cmd_blk,
   input  logic                      ext_stall,
   input  logic                      ext_rvalid,
   output logic                      busy,
   output logic                      ext_rd,
   output logic                      ext_wr,
   output logic [PAGE_W+BLK_W+BEAT_W-1:0] ext_addr,
   output logic [BLK_W-1:0]          blk_sel,
   output logic [BEAT_W-1:0]         pf_beat,
   output logic [BEAT_W-1:0]         rx_beat,
   output logic                      rx_we
);
   localparam int TAIL_N = RD_LAT + 1;
   localparam int TC_W   = $clog2(TAIL_N + 1);
   localparam logic [BEAT_W-1:0] LAST_BEAT = '1;
   localparam logic [TC_W-1:0]   TAIL_END  = TC_W'(TAIL_N - 1);

   xfer_state_t       state_q;
   logic              dir_load_q;
   logic [PAGE_W-1:0] page_q;
   logic [BLK_W-1:0]  blk_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] rx_beat_q;
   logic [TC_W-1:0]   tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         dir_load_q <= 1'b0;
         page_q     <= '0;
         blk_q      <= '0;
         beat_q     <= '0;
         rx_beat_q  <= '0;
         tail_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_load || cmd_store) begin
                  state_q    <= ST_WAIT;
                  dir_load_q <= cmd_load;   // load has precedence
                  page_q     <= cmd_page;
                  blk_q      <= cmd_blk;
                  beat_q     <= '0;
                  rx_beat_q  <= '0;
               end
            end
            ST_WAIT: begin
               if (!ext_stall) state_q <= ST_BURST;
            end
            ST_BURST: begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) begin
                  state_q <= ST_TAIL;
                  tail_q  <= '0;
               end
            end
            ST_TAIL: begin
               tail_q <= tail_q + 1'b1;
               if (tail_q == TAIL_END) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (state_q != ST_IDLE && dir_load_q && ext_rvalid)
            rx_beat_q <= rx_beat_q + 1'b1;
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign ext_wr   = (state_q == ST_BURST) && !dir_load_q;
   assign ext_rd   = (state_q == ST_BURST) && dir_load_q;
   assign ext_addr = {page_q, blk_q, beat_q};
   assign blk_sel  = blk_q;
   assign pf_beat  = (state_q == ST_BURST) ? beat_q + 1'b1 : '0;
   assign rx_beat  = rx_beat_q;
   assign rx_we    = busy && dir_load_q && ext_rvalid;
endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
   import blk_xfer_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int CACHE_AW = 10,
   parameter int BLK_W    = 4,
   parameter int PAGE_W   = 15,
   parameter int RD_LAT   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CACHE_AW-1:0]          usr_addr,
   input  logic                         usr_wr,
   input  logic [WORD_W-1:0]            usr_wdata,
   output logic [WORD_W-1:0]            usr_rdata,
   input  logic [PAGE_W-1:0]            cmd_page,
   input  logic [BLK_W-1:0]             cmd_blk,
   input  logic                         cmd_load,
   input  logic                         cmd_store,
   output logic                         busy,
   input  logic                         ext_stall,
   output logic                         ext_rd,
   output logic                         ext_wr,
   output logic [PAGE_W+CACHE_AW-2:0]   ext_addr,
   output logic [2*WORD_W-1:0]          ext_wdata,
   input  logic                         ext_rvalid,
   input  logic [2*WORD_W-1:0]          ext_rdata
);
   localparam int BANK_AW = CACHE_AW - 1;
   localparam int BEAT_W  = CACHE_AW - BLK_W - 1;

   generate
      if (BEAT_W < 1) begin : g_bad_geom
         $error("cache address too narrow for block index");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("read latency must be at least one cycle");
      end
   endgenerate

   logic [BLK_W-1:0]  blk_sel;
   logic [BEAT_W-1:0] pf_beat;
   logic [BEAT_W-1:0] rx_beat;
   logic              rx_we;
   logic              lane_q;
   logic [BANK_AW-1:0] xfer_addr;
   logic [WORD_W-1:0] usr_lane_rd [LANES];
   logic [WORD_W-1:0] xfer_lane_rd [LANES];

   xfer_sequencer #(
      .PAGE_W (PAGE_W),
      .BLK_W  (BLK_W),
      .BEAT_W (BEAT_W),
      .RD_LAT (RD_LAT)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_load   (cmd_load),
      .cmd_store  (cmd_store),
      .cmd_page   (cmd_page),
      .cmd_blk    (cmd_blk),
      .ext_stall  (ext_stall),
      .ext_rvalid (ext_rvalid),
      .busy       (busy),
      .ext_rd     (ext_rd),
      .ext_wr     (ext_wr),
      .ext_addr   (ext_addr),
      .blk_sel    (blk_sel),
      .pf_beat    (pf_beat),
      .rx_beat    (rx_beat),
      .rx_we      (rx_we)
   );

   // a load writes the arriving beat, otherwise the store prefetch is read
   assign xfer_addr = {blk_sel, (rx_we ? rx_beat : pf_beat)};

   genvar ln;
   generate
      for (ln = 0; ln < LANES; ln++) begin : g_lane
         xfer_cache_bank #(
            .DW (WORD_W),
            .AW (BANK_AW)
         ) bank_i (
            .clk     (clk),
            .a_addr  (usr_addr[CACHE_AW-1:1]),
            .a_we    (usr_wr && (usr_addr[0] == 1'(ln))),
            .a_wdata (usr_wdata),
            .a_rdata (usr_lane_rd[ln]),
            .b_addr  (xfer_addr),
            .b_we    (rx_we),
            .b_wdata (ext_rdata[ln*WORD_W +: WORD_W]),
            .b_rdata (xfer_lane_rd[ln])
         );
         assign ext_wdata[ln*WORD_W +: WORD_W] = xfer_lane_rd[ln];
      end
   endgenerate

   always_ff @(posedge clk) begin
      lane_q <= usr_addr[0];
   end

   assign usr_rdata = usr_lane_rd[lane_q];
endmodule

// File: rtl/blk_xfer_ctrl_chk.sv
module blk_xfer_ctrl_chk #(
   parameter int AW    = 24,
   parameter int BEATS = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          ext_rd,
   input logic          ext_wr,
   input logic [AW-1:0] ext_addr,
   input logic          cmd_load,
   input logic          cmd_store
);
   localparam int RC_W = $clog2(BEATS + 2) + 1;

   logic [RC_W-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) run_cnt <= '0;
      else if (ext_rd || ext_wr) run_cnt <= run_cnt + 1'b1;
      else run_cnt <= '0;
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ext_rd && !ext_wr));

   a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_rd && ext_wr));

   a_r4_wr_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && $past(ext_wr)) |-> (ext_addr == $past(ext_addr) + 1'b1));

   a_r5_rd_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd && $past(ext_rd)) |-> (ext_addr == $past(ext_addr) + 1'b1));

   a_r8_first_cycle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!ext_rd && !ext_wr));

   a_r6_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_load || cmd_store));

   a_r3_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= RC_W'(BEATS));

   a_r3_tail_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_rd || ext_wr) |-> busy);
endmodule

bind blk_xfer_ctrl blk_xfer_ctrl_chk #(
   .AW    (PAGE_W + CACHE_AW - 1),
   .BEATS (2 ** (CACHE_AW - BLK_W - 1))
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .ext_rd    (ext_rd),
   .ext_wr    (ext_wr),
   .ext_addr  (ext_addr),
   .cmd_load  (cmd_load),
   .cmd_store (cmd_store)
);

// File: tb/blk_xfer_ctrl_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  usr_addr = '0;
   logic        usr_wr = 1'b0;
   logic [31:0] usr_wdata = '0;
   logic [31:0] usr_rdata;
   logic [14:0] cmd_page = '0;
   logic [3:0]  cmd_blk = '0;
   logic        cmd_load = 1'b0;
   logic        cmd_store = 1'b0;
   logic        busy;
   logic        ext_stall = 1'b0;
   logic        ext_rd, ext_wr;
   logic [23:0] ext_addr;
   logic [63:0] ext_wdata;
   logic        ext_rvalid;
   logic [63:0] ext_rdata;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   blk_xfer_ctrl dut_i (
      .clk (clk), .rst_n (rst_n),
      .usr_addr (usr_addr), .usr_wr (usr_wr), .usr_wdata (usr_wdata), .usr_rdata (usr_rdata),
      .cmd_page (cmd_page), .cmd_blk (cmd_blk), .cmd_load (cmd_load), .cmd_store (cmd_store),
      .busy (busy), .ext_stall (ext_stall), .ext_rd (ext_rd), .ext_wr (ext_wr),
      .ext_addr (ext_addr), .ext_wdata (ext_wdata), .ext_rvalid (ext_rvalid), .ext_rdata (ext_rdata)
   );

   function automatic logic [63:0] pat(input logic [23:0] a);
      return {a ^ 24'hC3C3C3, 8'h1F, a, 8'hE0};
   endfunction

   function automatic logic [31:0] fill(input int i);
      return 32'hA500_0000 + 32'(i) * 32'h0101;
   endfunction

   // external memory model, two-cycle read latency
   logic        v1, v2;
   logic [23:0] a1, a2;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; a1 <= '0; a2 <= '0;
      end else begin
         v1 <= ext_rd; a1 <= ext_addr;
         v2 <= v1;     a2 <= a1;
      end
   end
   assign ext_rvalid = v2;
   assign ext_rdata  = v2 ? pat(a2) : 64'h0;

   // monitor
   int busy_cnt, wr_cnt, rd_cnt;
   logic [23:0] cap_addr [32];
   logic [63:0] cap_data [32];
   always @(negedge clk) begin
      if (busy) busy_cnt++;
      if (ext_rd) rd_cnt++;
      if (ext_wr) begin
         if (wr_cnt < 32) begin
            cap_addr[wr_cnt] = ext_addr;
            cap_data[wr_cnt] = ext_wdata;
         end
         wr_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      busy_cnt = 0; wr_cnt = 0; rd_cnt = 0;
   endtask

   task automatic usr_write(input int a, input logic [31:0] d);
      @(negedge clk);
      usr_addr = 10'(a); usr_wdata = d; usr_wr = 1'b1;
      @(negedge clk);
      usr_wr = 1'b0;
   endtask

   task automatic usr_read(input int a, output logic [31:0] d);
      @(negedge clk);
      usr_addr = 10'(a); usr_wr = 1'b0;
      @(negedge clk);
      d = usr_rdata;
   endtask

   task automatic start_xfer(input bit ld, input bit st, input logic [14:0] pg,
                             input logic [3:0] bk, input int stall);
      clr_mon();
      @(negedge clk);
      cmd_page = pg; cmd_blk = bk; cmd_load = ld; cmd_store = st;
      if (stall > 0) ext_stall = 1'b1;
      @(negedge clk);
      cmd_load = 1'b0; cmd_store = 1'b0;
      if (stall > 0) begin
         repeat (stall) @(negedge clk);
         ext_stall = 1'b0;
      end
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
      check(ext_rd == 1'b0 && ext_wr == 1'b0, "R1 ext strobes", {ext_rd, ext_wr}, 64'd0);
   endtask

   task automatic t_user_port();
      logic [31:0] d;
      usr_write(3, 32'h1234_5678);
      usr_write(4, 32'hCAFE_F00D);
      usr_read(3, d);
      check(d == 32'h1234_5678, "R2 read word 3", d, 32'h1234_5678);
      usr_read(4, d);
      check(d == 32'hCAFE_F00D, "R2 read word 4", d, 32'hCAFE_F00D);
   endtask

   task automatic t_store();
      int bad_a = 0, bad_d = 0;
      for (int i = 0; i < 64; i++) usr_write(5 * 64 + i, fill(i));
      start_xfer(1'b0, 1'b1, 15'h1234, 4'd5, 0);
      wait_idle();
      check(busy_cnt == 36, "R3 store busy length", busy_cnt, 36);
      check(wr_cnt == 32 && rd_cnt == 0, "R4 store beat count", {32'(wr_cnt), 32'(rd_cnt)}, {32'd32, 32'd0});
      for (int b = 0; b < 32; b++) begin
         if (cap_addr[b] != {15'h1234, 4'd5, 5'(b)}) bad_a++;
         if (cap_data[b] != {fill(2 * b + 1), fill(2 * b)}) bad_d++;
      end
      check(bad_a == 0, "R4 store addresses", bad_a, 0);
      check(bad_d == 0, "R4 store data", bad_d, 0);
   endtask

   task automatic t_load();
      int bad = 0;
      logic [31:0] d;
      logic [63:0] p;
      usr_write(9 * 64 - 1, 32'h5EA7_0001);
      usr_write(10 * 64, 32'h5EA7_0002);
      start_xfer(1'b1, 1'b0, 15'h0ABC, 4'd9, 0);
      wait_idle();
      check(busy_cnt == 36, "R3 load busy length", busy_cnt, 36);
      check(rd_cnt == 32 && wr_cnt == 0, "R5 load beat count", {32'(rd_cnt), 32'(wr_cnt)}, {32'd32, 32'd0});
      for (int w = 0; w < 64; w++) begin
         usr_read(9 * 64 + w, d);
         p = pat({15'h0ABC, 4'd9, 5'(w / 2)});
         if (d != ((w % 2 == 1) ? p[63:32] : p[31:0])) bad++;
      end
      check(bad == 0, "R5 load data in cache", bad, 0);
      usr_read(9 * 64 - 1, d);
      check(d == 32'h5EA7_0001, "R9 word below block", d, 32'h5EA7_0001);
      usr_read(10 * 64, d);
      check(d == 32'h5EA7_0002, "R9 word above block", d, 32'h5EA7_0002);
   endtask

   task automatic t_stall();
      start_xfer(1'b0, 1'b1, 15'h0007, 4'd5, 5);
      wait_idle();
      check(busy_cnt == 41, "R8 stalled busy length", busy_cnt, 41);
      check(wr_cnt == 32, "R8 beats after stall", wr_cnt, 32);
   endtask

   task automatic t_ignore_busy();
      logic [31:0] d;
      start_xfer(1'b0, 1'b1, 15'h0001, 4'd5, 0);
      repeat (8) @(negedge clk);
      cmd_load = 1'b1; cmd_store = 1'b1; cmd_blk = 4'd9;
      @(negedge clk);
      cmd_load = 1'b0; cmd_store = 1'b0;
      usr_read(3, d);
      check(busy == 1'b1, "R10 still busy during read", 64'(busy), 64'd1);
      check(d == 32'h1234_5678, "R10 read during transfer", d, 32'h1234_5678);
      wait_idle();
      check(busy_cnt == 36 && rd_cnt == 0, "R6 command while busy ignored",
            {32'(busy_cnt), 32'(rd_cnt)}, {32'd36, 32'd0});
      repeat (4) @(negedge clk);
      check(busy == 1'b0 && busy_cnt == 36, "R6 no later transfer", {32'(busy_cnt), 31'd0, busy},
            {32'd36, 32'd0});
   endtask

   task automatic t_both();
      start_xfer(1'b1, 1'b1, 15'h0002, 4'd9, 0);
      wait_idle();
      check(rd_cnt == 32 && wr_cnt == 0, "R7 load wins", {32'(rd_cnt), 32'(wr_cnt)}, {32'd32, 32'd0});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_user_port();
      t_store();
      t_load();
      t_stall();
      t_ignore_busy();
      t_both();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule